// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block works out the three divider settings for a clock synthesizer PLL with a feedback, input and post-divider stage. It takes a reference frequency and a requested output frequency, both in 100 Hz units. It limits the request to a given window and picks a power-of-two post-divider so that the oscillator lands in its legal band. It then walks through the input-divider candidates, one per clock cycle, and keeps the candidate whose ideal feedback value lies closest to a whole number.

All arithmetic is unsigned fixed point with 16 fractional bits. One sequential restoring divider is shared by two steps: the per-step increment before the search, and the achieved output frequency after it. The results are the register encodings of the two dividers, the post-divider exponent, the frequency that the chosen settings really produce, and a flag for the case where no candidate qualifies. A caller starts the engine with a single-cycle start, watches busy, and takes the results on the one-cycle done pulse.

Top module: `pll_mnp_search`

## Requirements
- R1: At start the requested clock is limited to the window: a value below the minimum becomes the minimum, then a value above the maximum becomes the maximum. Only the limited value affects the results.
- R2: The post-divider exponent starts at 0. While the exponent is below 3 and the target is below 1,100,000 (110 MHz in 100 Hz units), the target doubles and the exponent rises by one. `p_sel` reports the final exponent with no encoding.
- R3: The step increment is floor(target·2^16 / (8·reference)). The ideal feedback value for input-divider candidate n (n = 3..25) is n times the increment, in 16-fractional-bit fixed point.
- R4: A candidate whose ideal feedback value is below 3.0 or above 64.0 is skipped. Exactly 3.0 and exactly 64.0 are accepted.
- R5: Among the accepted candidates, the one with the smallest fractional part wins. The starting error is 2.0 and a later candidate replaces the best only on a strictly smaller fraction, so the lowest n wins a tie.
- R6: `m_code` = 65 − (integer part of the winner's feedback value) and `n_code` = 65 − (winning n).
- R7: `act_clk` = floor(8·reference·m / n) shifted right by the exponent, using the winning integer m and n.
- R8: If no candidate is accepted, `no_solution` is 1, `m_code` and `n_code` are both 65, and `act_clk` is 0. Otherwise `no_solution` is 0.
- R9: A start pulse while busy is high is ignored. The running computation keeps its captured inputs and no extra done pulse follows.
- R10: Busy rises in the cycle after an accepted start and stays high until the results are published. Done is a single-cycle pulse with busy low, and all result outputs hold their values until the next done.
- R11: After reset, busy, done, `no_solution`, `p_sel`, `act_clk`, `m_code` and `n_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation (taken only while idle) |
| ref_clk | input | CW | Reference frequency, 100 Hz units |
| req_clk | input | CW | Requested output frequency, 100 Hz units |
| min_clk | input | CW | Lower limit for the request |
| max_clk | input | CW | Upper limit for the request |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| m_code | output | 7 | Feedback divider code, 65 − m |
| n_code | output | 7 | Input divider code, 65 − n |
| p_sel | output | 2 | Post-divider exponent |
| act_clk | output | CW+8 | Achieved output frequency, 100 Hz units |
| no_solution | output | 1 | No candidate passed the range test |

## Verification
Most internal faults surface in a single result. A bad increment or a broken accumulator shifts which candidate wins, so `n_code`, `m_code` and `act_clk` change together at the next done, about a hundred cycles after start. A wrong tie rule shows up only when several candidates share a fraction, so exact-integer ratios are driven on purpose. A flaw in the exponent loop or the window limits shows in `p_sel` and in runs that should match. Sweeping the request across and past the window at several reference frequencies compares every done against an arithmetic model that multiplies where the hardware adds.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

  // Candidate window for the input divider
  localparam int N_FIRST   = 3;
  localparam int N_LAST    = 25;
  // Legal integer range of the ideal feedback value
  localparam int M_LO      = 3;
  localparam int M_HI      = 64;
  // Register encoding base: code = base - value
  localparam int CODE_BASE = 65;
  // Largest post-divider exponent
  localparam int P_MAX     = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCALE,
    ST_INC_DIV,
    ST_SEARCH,
    ST_CLK_GO,
    ST_CLK_DIV,
    ST_FINISH
  } srch_st_e;

endpackage

// File: rtl/pll_div_seq.sv
// Restoring divider, one quotient bit per cycle, MSB first.
module pll_div_seq #(
  parameter int NW = 43,
  parameter int DW = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          valid,
  output logic [NW-1:0] quot
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DW-1:0]   rem_q;
  logic [DW-1:0]   den_q;
  logic [NW-1:0]   sh_q;
  logic [CNTW-1:0] cnt_q;
  logic [DW:0]     trial;
  logic [DW:0]     diff;
  logic            fits;

  assign trial = {rem_q, sh_q[NW-1]};
  assign fits  = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};
  assign quot  = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go && !busy) begin
        sh_q  <= num;
        den_q <= den;
        rem_q <= '0;
        cnt_q <= CNTW'(NW);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? diff[DW-1:0] : trial[DW-1:0];
        sh_q  <= {sh_q[NW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  // R7
  div_go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
  // R7
  div_valid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);

endmodule

// File: rtl/pll_cand_eval.sv
// Judges one candidate's accumulated feedback value against the best so far.
module pll_cand_eval
  import pll_srch_pkg::*;
#(
  parameter int AW = 48,
  parameter int FB = 16
) (
  input  logic [AW-1:0] acc,
  input  logic [FB+1:0] best_err,
  output logic          in_range,
  output logic          take,
  output logic [6:0]    m_int,
  output logic [FB-1:0] frac
);
  localparam logic [AW-1:0] LO_FX = AW'(M_LO) << FB;
  localparam logic [AW-1:0] HI_FX = AW'(M_HI) << FB;

  assign in_range = (acc >= LO_FX) && (acc <= HI_FX);
  assign frac     = acc[FB-1:0];
  assign m_int    = acc[FB+6:FB];
  assign take     = in_range && ({2'b00, frac} < best_err);

endmodule

// File: rtl/pll_mnp_search.sv
module pll_mnp_search
  import pll_srch_pkg::*;
#(
  parameter int CW      = 24,
  parameter int FB      = 16,
  parameter int VCO_MIN = 1100000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   ref_clk,
  input  logic [CW-1:0]   req_clk,
  input  logic [CW-1:0]   min_clk,
  input  logic [CW-1:0]   max_clk,
  output logic            busy,
  output logic            done,
  output logic [6:0]      m_code,
  output logic [6:0]      n_code,
  output logic [1:0]      p_sel,
  output logic [CW+7:0]   act_clk,
  output logic            no_solution
);
  localparam int VW  = CW + 3;       // target after up to three doublings
  localparam int NW  = VW + FB;      // divider numerator / quotient
  localparam int DW  = VW;           // divider denominator
  localparam int AW  = NW + 5;       // accumulator, holds 25 increments
  localparam int PW  = CW + 10;      // 8 * ref * m
  localparam int AKW = CW + 8;       // achieved clock width

  srch_st_e       st_q;
  logic [CW-1:0]  ref_q;
  logic [VW-1:0]  tgt_q;
  logic [1:0]     p_q;
  logic [NW-1:0]  inc_q;
  logic [AW-1:0]  acc_q;
  logic [4:0]     n_q;
  logic [6:0]     best_m_q;
  logic [4:0]     best_n_q;
  logic [FB+1:0]  best_err_q;
  logic [AKW-1:0] act_q;

  // Named internal events
  logic           scale_more;
  logic           accept_start;
  logic           search_last;
  logic           cand_in_range;
  logic           cand_take;
  logic [6:0]     cand_m;
  logic [FB-1:0]  cand_frac;
  logic           div_go;
  logic [NW-1:0]  div_num;
  logic [DW-1:0]  div_den;
  logic           div_busy;
  logic           div_valid;
  logic [NW-1:0]  div_quot;
  logic [PW-1:0]  clk_num;

  function automatic logic [CW-1:0] clamp_req(input logic [CW-1:0] r,
                                              input logic [CW-1:0] lo,
                                              input logic [CW-1:0] hi);
    logic [CW-1:0] t;
    t = r;
    if (t < lo) t = lo;
    if (t > hi) t = hi;
    return t;
  endfunction

  function automatic logic [6:0] enc_code(input logic [6:0] v);
    return 7'(CODE_BASE) - v;
  endfunction

  assign busy         = (st_q != ST_IDLE);
  assign accept_start = (st_q == ST_IDLE) && start;
  assign scale_more   = (p_q != 2'(P_MAX)) && (tgt_q < VW'(VCO_MIN));
  assign search_last  = (st_q == ST_SEARCH) && (n_q == 5'(N_LAST));
  assign clk_num      = PW'({ref_q, 3'b000}) * PW'(best_m_q);

  always_comb begin
    div_go  = 1'b0;
    div_num = '0;
    div_den = '0;
    if (st_q == ST_SCALE && !scale_more) begin
      div_go  = 1'b1;
      div_num = {tgt_q, {FB{1'b0}}};
      div_den = {ref_q, 3'b000};
    end else if (st_q == ST_CLK_GO) begin
      div_go  = 1'b1;
      div_num = NW'(clk_num);
      div_den = DW'(best_n_q);
    end
  end

  pll_div_seq #(.NW(NW), .DW(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .valid (div_valid),
    .quot  (div_quot)
  );

  pll_cand_eval #(.AW(AW), .FB(FB)) u_cand (
    .acc      (acc_q),
    .best_err (best_err_q),
    .in_range (cand_in_range),
    .take     (cand_take),
    .m_int    (cand_m),
    .frac     (cand_frac)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      ref_q       <= '0;
      tgt_q       <= '0;
      p_q         <= '0;
      inc_q       <= '0;
      acc_q       <= '0;
      n_q         <= '0;
      best_m_q    <= '0;
      best_n_q    <= '0;
      best_err_q  <= '0;
      act_q       <= '0;
      done        <= 1'b0;
      m_code      <= '0;
      n_code      <= '0;
      p_sel       <= '0;
      act_clk     <= '0;
      no_solution <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept_start) begin
            ref_q <= ref_clk;
            tgt_q <= VW'(clamp_req(req_clk, min_clk, max_clk));
            p_q   <= '0;
            st_q  <= ST_SCALE;
          end
        end
        ST_SCALE: begin
          if (scale_more) begin
            tgt_q <= {tgt_q[VW-2:0], 1'b0};
            p_q   <= p_q + 2'd1;
          end else begin
            st_q <= ST_INC_DIV;
          end
        end
        ST_INC_DIV: begin
          if (div_valid) begin
            inc_q      <= div_quot;
            acc_q      <= AW'(div_quot) * AW'(N_FIRST);
            n_q        <= 5'(N_FIRST);
            best_m_q   <= '0;
            best_n_q   <= '0;
            best_err_q <= (FB+2)'(2) << FB;
            act_q      <= '0;
            st_q       <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (cand_take) begin
            best_err_q <= {2'b00, cand_frac};
            best_m_q   <= cand_m;
            best_n_q   <= n_q;
          end
          acc_q <= acc_q + AW'(inc_q);
          n_q   <= n_q + 5'd1;
          if (search_last)
            st_q <= (cand_take || best_n_q != '0) ? ST_CLK_GO : ST_FINISH;
        end
        ST_CLK_GO: begin
          st_q <= ST_CLK_DIV;
        end
        ST_CLK_DIV: begin
          if (div_valid) begin
            act_q <= AKW'(div_quot >> p_q);
            st_q  <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          done        <= 1'b1;
          m_code      <= enc_code(best_m_q);
          n_code      <= enc_code({2'b00, best_n_q});
          p_sel       <= p_q;
          act_clk     <= act_q;
          no_solution <= (best_n_q == '0);
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(ref_q));
  // R2
  p_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCALE && p_q == 2'd3) |=> (st_q == ST_INC_DIV));
  // R4
  n_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEARCH) |-> (n_q >= 5'd3 && n_q <= 5'd25));
  // R4
  best_m_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEARCH && cand_take) |=> (best_m_q >= 7'd3 && best_m_q <= 7'd64));
  // R5
  err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEARCH) |=> (best_err_q <= $past(best_err_q)));
  // R8
  nosol_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_solution) |-> (act_clk == '0 && m_code == 7'd65 && n_code == 7'd65));
  // R6
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_solution) |-> (m_code >= 7'd1 && m_code <= 7'd62 &&
                                n_code >= 7'd40 && n_code <= 7'd62));
  // R7
  clk_div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CLK_GO) |-> !div_busy);

endmodule

// File: tb/sim_pll_mnp_search.sv
module sim_pll_mnp_search;
  localparam int CW   = 24;
  localparam longint unsigned VMIN = 1100000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [CW-1:0]   ref_clk = '0, req_clk = '0, min_clk = '0, max_clk = '0;
  logic            busy, done, no_solution;
  logic [6:0]      m_code, n_code;
  logic [1:0]      p_sel;
  logic [CW+7:0]   act_clk;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pll_mnp_search #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ref_clk(ref_clk), .req_clk(req_clk), .min_clk(min_clk), .max_clk(max_clk),
    .busy(busy), .done(done), .m_code(m_code), .n_code(n_code),
    .p_sel(p_sel), .act_clk(act_clk), .no_solution(no_solution)
  );

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Arithmetic model: candidate value as n * increment (multiplied, not summed)
  task automatic model(input longint unsigned rf, input longint unsigned rq,
                       input longint unsigned lo, input longint unsigned hi,
                       output longint unsigned em, output longint unsigned en,
                       output longint unsigned ep, output longint unsigned eact,
                       output longint unsigned enos);
    longint unsigned t, inc, err, bm, bn, a, f;
    t = rq;
    if (t < lo) t = lo;
    if (t > hi) t = hi;
    ep = 0;
    while (ep < 3 && t < VMIN) begin
      t = t * 2;
      ep++;
    end
    inc = (t << 16) / (rf * 8);
    err = 64'd2 << 16;
    bm = 0;
    bn = 0;
    for (longint unsigned n = 3; n <= 25; n++) begin
      a = n * inc;
      if (a < (64'd3 << 16) || a > (64'd64 << 16)) continue;
      f = a % 65536;
      if (f < err) begin
        err = f;
        bm = a / 65536;
        bn = n;
      end
    end
    em = 65 - bm;
    en = 65 - bn;
    enos = (bn == 0) ? 1 : 0;
    eact = (bn == 0) ? 0 : (((8 * rf * bm) / bn) >> ep);
  endtask

  // Launch a run; optionally pulse start again while busy with other inputs
  task automatic run(input longint unsigned rf, input longint unsigned rq,
                     input longint unsigned lo, input longint unsigned hi,
                     input bit disturb, output bit ok);
    int wait_cnt;
    @(negedge clk);
    ref_clk = CW'(rf); req_clk = CW'(rq); min_clk = CW'(lo); max_clk = CW'(hi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", busy, 1);
    wait_cnt = 0;
    ok = 1'b1;
    while (!done) begin
      if (disturb && wait_cnt == 4) begin
        ref_clk = CW'(rf + 12345); req_clk = CW'(rq + 400000); start = 1'b1;
      end else if (disturb && wait_cnt == 30) begin
        ref_clk = CW'(7); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      wait_cnt++;
      if (wait_cnt > 2000) begin
        fails++;
        tests++;
        $display("FAIL R10 run timeout actual=%0d expected=%0d", wait_cnt, 2000);
        ok = 1'b0;
        break;
      end
    end
    start = 1'b0;
    if (ok) chk("R10 idle at done", busy, 0);
  endtask

  task automatic compare(input string tag, input longint unsigned rf, input longint unsigned rq,
                         input longint unsigned lo, input longint unsigned hi);
    longint unsigned em, en, ep, ea, ens;
    model(rf, rq, lo, hi, em, en, ep, ea, ens);
    chk({tag, " R6 m_code"}, m_code, em);
    chk({tag, " R3 R5 n_code"}, n_code, en);
    chk({tag, " R2 p_sel"}, p_sel, ep);
    chk({tag, " R7 act_clk"}, act_clk, ea);
    chk({tag, " R8 no_solution"}, no_solution, ens);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    bit ok;
    longint unsigned sm, sn, sa;
    longint unsigned refs [4] = '{143182, 250000, 500000, 1000000};

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 m_code", m_code, 0);
    chk("R11 n_code", n_code, 0);
    chk("R11 act_clk", act_clk, 0);
    chk("R11 no_solution", no_solution, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 exact-integer ratio: every candidate has zero fraction, lowest n wins
    run(50000, 1200000, 100000, 2000000, 1'b0, ok);
    chk("R5 tie n_code", n_code, 62);
    chk("R6 tie m_code", m_code, 56);
    chk("R7 tie act_clk", act_clk, 1200000);
    chk("R2 tie p_sel", p_sel, 0);
    @(negedge clk);
    chk("R10 done single pulse", done, 0);

    // R2 exponent saturates at 3
    run(143182, 150000, 100000, 2200000, 1'b0, ok);
    chk("R2 p saturates", p_sel, 3);
    compare("p3", 143182, 150000, 100000, 2200000);
    run(143182, 1500000, 100000, 2200000, 1'b0, ok);
    chk("R2 p zero", p_sel, 0);

    // R4 boundary: low candidates fall just under 3.0
    run(500000, 1200000, 100000, 2200000, 1'b0, ok);
    compare("R4 edge", 500000, 1200000, 100000, 2200000);

    // R8 no candidate: too large and too small increments
    run(100, 1200000, 100000, 2200000, 1'b0, ok);
    chk("R8 flag big inc", no_solution, 1);
    chk("R8 m_code", m_code, 65);
    chk("R8 n_code", n_code, 65);
    chk("R8 act_clk", act_clk, 0);
    run(16000000, 1200000, 100000, 2200000, 1'b0, ok);
    chk("R8 flag small inc", no_solution, 1);

    // R1 below the window behaves as the minimum
    run(250000, 50000, 300000, 2000000, 1'b0, ok);
    sm = m_code; sn = n_code; sa = act_clk;
    run(250000, 300000, 300000, 2000000, 1'b0, ok);
    chk("R1 low m", m_code, sm);
    chk("R1 low n", n_code, sn);
    chk("R1 low act", act_clk, sa);
    // R1 above the window behaves as the maximum
    run(250000, 3000000, 300000, 2000000, 1'b0, ok);
    sa = act_clk;
    run(250000, 2000000, 300000, 2000000, 1'b0, ok);
    chk("R1 high act", act_clk, sa);

    // R9 start pulses while busy are ignored
    run(143182, 700000, 200000, 2200000, 1'b1, ok);
    compare("R9 disturbed", 143182, 700000, 200000, 2200000);
    repeat (3) begin
      @(negedge clk);
      chk("R9 no extra done", done, 0);
      chk("R9 stays idle", busy, 0);
    end

    // Sweep across and past the window at several references
    foreach (refs[i]) begin
      for (longint unsigned rq = 200000; rq <= 2400000; rq += 100000) begin
        run(refs[i], rq, 250000, 2200000, 1'b0, ok);
        compare("sweep", refs[i], rq, 250000, 2200000);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule